// File: doc/BRIEF.md
# Data Cache Maintenance Controller

This block is the maintenance front end of a small direct-mapped write-back data cache. It owns the per-line valid, dirty and tag state and a control word. It carries out the maintenance commands that software issues through a register-write channel: invalidate or write back the whole cache, or invalidate or write back a single line. A command that needs write-backs walks the affected lines in ascending index order. Each dirty line it meets goes out as one request on a valid/ready memory port.

The control word has three meaningful bits. One bit switches the cache off. One bit picks what every invalidate command does: either a plain discard, or a write-back of dirty lines followed by the discard. One read-only bit shows that a walk with write-backs is in progress. The load/store pipeline reports line fills through a plain fill port. A lookup port returns the valid and dirty flags of the line that an address selects. Per-line commands select their line by the index bits of the written address. They do no tag comparison.

Both data channels use valid/ready. The command channel holds `cmd_ready` low for as long as a walk runs. A waiting command must keep `cmd_valid`, `cmd_sel` and `cmd_wdata` stable and is taken on the first edge where `cmd_ready` is high. The write-back channel raises `wb_valid` and holds it and `wb_addr` steady until the edge where `wb_ready` is high. The memory side may stall for any number of cycles.

Top module: `dcache_maint`

## Requirements
- R1: After reset the control word reads 0 (cache on, discard mode, idle), `cmd_ready` is 1, `wb_valid` is 0 and no line is valid.
- R2: A command with `cmd_sel`=0 loads the control word. Data bit 0 becomes the disable bit, read back at bit 0 of `ctrl_rd`, and data bit 6 becomes the invalidate mode bit, read back at bit 6. All other bits of `ctrl_rd` except bit 8 read 0. `cache_on` is the inverse of bit 0, and while bit 0 is set the fill port is ignored.
- R3: Bit 8 of `ctrl_rd` is 1 from the edge that accepts a command with write-back until the walk ends. Those commands are `cmd_sel`=2, `cmd_sel`=4, and `cmd_sel`=1 or 3 when bit 6 is 1. A plain invalidate (`cmd_sel`=1 or 3 with bit 6 at 0) never raises it.
- R4: A whole-cache invalidate (`cmd_sel`=1) with bit 6 at 0 clears every valid and dirty bit at the accepting edge and makes no memory request.
- R5: A whole-cache flush (`cmd_sel`=2) writes back every valid dirty line exactly once, in ascending index order. It then leaves those lines valid and clean.
- R6: With bit 6 at 1, an invalidate (`cmd_sel`=1 for the whole cache, 3 for one line) writes back each affected dirty line and then leaves every affected line invalid.
- R7: A per-line invalidate (`cmd_sel`=3) or per-line flush (`cmd_sel`=4) acts only on the line whose index is in `cmd_wdata` bits [8:5] (default parameters). The offset bits [4:0] are ignored.
- R8: A flush of a clean line and an invalidate of a line that is not valid finish without any memory request.
- R9: `wb_addr` is the stored tag, then the line index, then zero offset bits. Once raised, `wb_valid` and `wb_addr` are held until `wb_ready` is seen.
- R10: While bit 8 is set, `cmd_ready` is 0. A command presented then is held, not dropped, and takes effect after the walk ends.
- R11: `lkp_valid` and `lkp_dirty` show, without a clock edge, the flags of the line selected by the index bits of `lkp_addr`.
- R12: A fill (`fill_valid` high while the cache is on) makes the line valid, stores the tag of `fill_addr`, and sets the dirty bit when `fill_dirty` is 1. Otherwise it leaves the dirty bit as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Register write request |
| cmd_ready | output | 1 | Register write accepted on this edge when high |
| cmd_sel | input | 3 | 0 control, 1 invalidate all, 2 flush all, 3 invalidate line, 4 flush line |
| cmd_wdata | input | ADDR_W | Control data or line address |
| ctrl_rd | output | 32 | Control word: bit 0 disable, bit 6 invalidate mode, bit 8 busy |
| cache_on | output | 1 | High when the cache is enabled |
| fill_valid | input | 1 | A line fill from the pipeline |
| fill_addr | input | ADDR_W | Address of the filled line |
| fill_dirty | input | 1 | Filled line is to be marked dirty |
| lkp_addr | input | ADDR_W | Lookup address |
| lkp_valid | output | 1 | Valid flag of the looked-up line |
| lkp_dirty | output | 1 | Dirty flag of the looked-up line |
| wb_valid | output | 1 | Write-back request |
| wb_ready | input | 1 | Memory takes the write-back |
| wb_addr | output | ADDR_W | Line address of the write-back |

## Verification
The bench targets the mode bit. A design that ignored it on per-line commands would silently drop dirty data, or would write back a line that a plain invalidate was meant to discard. It also checks that a clean line or an absent line produces no memory request, where a careless walker would emit spurious writes. A write-back request is stalled for several cycles to catch a design that moves its address or drops the request. A command is issued in the middle of a stalled walk; a design that dropped it, or ran it early, would leave the wrong line state afterwards. Per-line addresses carry non-zero offset bits to show that only the index selects the line.

// File: rtl/dcm_pkg.sv
`timescale 1ns/1ps
package dcm_pkg;
  localparam int CTRL_W    = 32;
  localparam int DIS_BIT   = 0;
  localparam int IMODE_BIT = 6;
  localparam int BUSY_BIT  = 8;

  typedef enum logic [2:0] {
    SEL_CTRL       = 3'd0,
    SEL_INV_ALL    = 3'd1,
    SEL_FLUSH_ALL  = 3'd2,
    SEL_INV_LINE   = 3'd3,
    SEL_FLUSH_LINE = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    WALK_IDLE  = 2'd0,
    WALK_SCAN  = 2'd1,
    WALK_WRITE = 2'd2
  } walk_state_e;
endpackage

// File: rtl/dcm_cmd_decode.sv
`timescale 1ns/1ps
module dcm_cmd_decode
  import dcm_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_sel,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic             wd_dis,
  input  logic             wd_mode,
  input  logic             busy,
  output logic             cmd_ready,
  output logic             ctrl_dis,
  output logic             ctrl_imode,
  output logic             inv_all,
  output logic             line_clr,
  output logic [IDX_W-1:0] line_idx,
  output logic             walk_start,
  output logic [IDX_W-1:0] walk_first,
  output logic [IDX_W-1:0] walk_last,
  output logic             walk_inv
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

  reg_sel_e sel_e;
  logic     acc;

  assign sel_e     = reg_sel_e'(cmd_sel);
  assign cmd_ready = ~busy;
  assign acc       = cmd_valid & cmd_ready;
  assign line_idx  = cmd_idx;

  // Turn an accepted write into either an immediate clear or a walk.
  always_comb begin
    inv_all    = 1'b0;
    line_clr   = 1'b0;
    walk_start = 1'b0;
    walk_first = '0;
    walk_last  = LAST_IDX;
    walk_inv   = 1'b0;
    if (acc) begin
      case (sel_e)
        SEL_INV_ALL: begin
          if (ctrl_imode) begin
            walk_start = 1'b1;
            walk_inv   = 1'b1;
          end else begin
            inv_all = 1'b1;
          end
        end
        SEL_FLUSH_ALL: walk_start = 1'b1;
        SEL_INV_LINE: begin
          if (ctrl_imode) begin
            walk_start = 1'b1;
            walk_inv   = 1'b1;
            walk_first = cmd_idx;
            walk_last  = cmd_idx;
          end else begin
            line_clr = 1'b1;
          end
        end
        SEL_FLUSH_LINE: begin
          walk_start = 1'b1;
          walk_first = cmd_idx;
          walk_last  = cmd_idx;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_dis   <= 1'b0;
      ctrl_imode <= 1'b0;
    end else if (acc && sel_e == SEL_CTRL) begin
      ctrl_dis   <= wd_dis;
      ctrl_imode <= wd_mode;
    end
  end
endmodule

// File: rtl/dcm_line_state.sv
`timescale 1ns/1ps
module dcm_line_state #(
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = 4,
  parameter int TAG_W     = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fill_en,
  input  logic [IDX_W-1:0]     fill_idx,
  input  logic [TAG_W-1:0]     fill_tag,
  input  logic                 fill_dirty,
  input  logic                 clr_all,
  input  logic                 clr_en,
  input  logic [IDX_W-1:0]     clr_idx,
  input  logic                 clr_valid,
  input  logic [IDX_W-1:0]     rd_a_idx,
  output logic                 rd_a_valid,
  output logic                 rd_a_dirty,
  output logic [TAG_W-1:0]     rd_a_tag,
  input  logic [IDX_W-1:0]     rd_b_idx,
  output logic                 rd_b_valid,
  output logic                 rd_b_dirty,
  output logic [NUM_LINES-1:0] valid_vec
);
  logic [NUM_LINES-1:0] dirty_vec;
  logic [TAG_W-1:0]     tag_arr [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic             v_q;
    logic             d_q;
    logic [TAG_W-1:0] t_q;
    logic             fill_hit;
    logic             clr_hit;

    assign fill_hit = fill_en & (fill_idx == IDX_W'(g));
    assign clr_hit  = clr_en  & (clr_idx  == IDX_W'(g));

    // Maintenance clears take precedence over a fill on the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        t_q <= '0;
      end else if (clr_all) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (clr_hit) begin
        d_q <= 1'b0;
        if (clr_valid) v_q <= 1'b0;
      end else if (fill_hit) begin
        v_q <= 1'b1;
        t_q <= fill_tag;
        if (fill_dirty) d_q <= 1'b1;
      end
    end

    assign valid_vec[g] = v_q;
    assign dirty_vec[g] = d_q;
    assign tag_arr[g]   = t_q;
  end

  assign rd_a_valid = valid_vec[rd_a_idx];
  assign rd_a_dirty = dirty_vec[rd_a_idx];
  assign rd_a_tag   = tag_arr[rd_a_idx];
  assign rd_b_valid = valid_vec[rd_b_idx];
  assign rd_b_dirty = dirty_vec[rd_b_idx];
endmodule

// File: rtl/dcm_walker.sv
`timescale 1ns/1ps
module dcm_walker
  import dcm_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] first,
  input  logic [IDX_W-1:0] last,
  input  logic             do_inv,
  input  logic             cur_valid,
  input  logic             cur_dirty,
  input  logic             wb_ready,
  output logic             busy,
  output logic [IDX_W-1:0] cur_idx,
  output logic             wb_valid,
  output logic             clr_en,
  output logic             clr_valid
);
  walk_state_e      state_q, state_d;
  logic [IDX_W-1:0] cur_q, last_q;
  logic             inv_q;
  logic             advance;
  logic             at_end;

  assign busy     = (state_q != WALK_IDLE);
  assign wb_valid = (state_q == WALK_WRITE);
  assign cur_idx  = cur_q;
  assign at_end   = (cur_q == last_q);

  // One line per cycle when nothing needs writing; stay on a dirty line
  // until memory takes it.
  always_comb begin
    state_d   = state_q;
    clr_en    = 1'b0;
    clr_valid = 1'b0;
    advance   = 1'b0;
    case (state_q)
      WALK_SCAN: begin
        if (cur_valid && cur_dirty) begin
          state_d = WALK_WRITE;
        end else begin
          advance = 1'b1;
          if (inv_q) begin
            clr_en    = 1'b1;
            clr_valid = 1'b1;
          end
        end
      end
      WALK_WRITE: begin
        if (wb_ready) begin
          advance   = 1'b1;
          clr_en    = 1'b1;
          clr_valid = inv_q;
        end
      end
      default: ;
    endcase
    if (advance) state_d = at_end ? WALK_IDLE : WALK_SCAN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      cur_q   <= '0;
      last_q  <= '0;
      inv_q   <= 1'b0;
    end else if (state_q == WALK_IDLE) begin
      if (start) begin
        state_q <= WALK_SCAN;
        cur_q   <= first;
        last_q  <= last;
        inv_q   <= do_inv;
      end
    end else begin
      state_q <= state_d;
      if (advance && !at_end) cur_q <= cur_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/dcache_maint.sv
`timescale 1ns/1ps
module dcache_maint
  import dcm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_sel,
  input  logic [ADDR_W-1:0] cmd_wdata,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic              cache_on,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_dirty,
  input  logic [ADDR_W-1:0] lkp_addr,
  output logic              lkp_valid,
  output logic              lkp_dirty,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic                 busy;
  logic                 ctrl_dis, ctrl_imode;
  logic                 inv_all, line_clr;
  logic [IDX_W-1:0]     line_idx;
  logic                 walk_start, walk_inv;
  logic [IDX_W-1:0]     walk_first, walk_last, walk_idx;
  logic                 walk_clr, walk_clr_valid;
  logic                 cur_valid, cur_dirty;
  logic [TAG_W-1:0]     cur_tag;
  logic                 clr_en, clr_valid;
  logic [IDX_W-1:0]     clr_idx;
  logic [NUM_LINES-1:0] line_valid_vec;
  logic                 unused_bits;

  assign unused_bits = ^{cmd_wdata, fill_addr[OFF_W-1:0], lkp_addr};

  dcm_cmd_decode #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_sel    (cmd_sel),
    .cmd_idx    (cmd_wdata[OFF_W +: IDX_W]),
    .wd_dis     (cmd_wdata[DIS_BIT]),
    .wd_mode    (cmd_wdata[IMODE_BIT]),
    .busy       (busy),
    .cmd_ready  (cmd_ready),
    .ctrl_dis   (ctrl_dis),
    .ctrl_imode (ctrl_imode),
    .inv_all    (inv_all),
    .line_clr   (line_clr),
    .line_idx   (line_idx),
    .walk_start (walk_start),
    .walk_first (walk_first),
    .walk_last  (walk_last),
    .walk_inv   (walk_inv)
  );

  dcm_walker #(.IDX_W(IDX_W)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (walk_start),
    .first     (walk_first),
    .last      (walk_last),
    .do_inv    (walk_inv),
    .cur_valid (cur_valid),
    .cur_dirty (cur_dirty),
    .wb_ready  (wb_ready),
    .busy      (busy),
    .cur_idx   (walk_idx),
    .wb_valid  (wb_valid),
    .clr_en    (walk_clr),
    .clr_valid (walk_clr_valid)
  );

  // The walker and the immediate line clear never act in the same cycle:
  // the decoder only accepts commands while the walker is idle.
  assign clr_en    = walk_clr | line_clr;
  assign clr_idx   = busy ? walk_idx : line_idx;
  assign clr_valid = busy ? walk_clr_valid : 1'b1;

  dcm_line_state #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_lines (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_en    (fill_valid & ~ctrl_dis),
    .fill_idx   (fill_addr[OFF_W +: IDX_W]),
    .fill_tag   (fill_addr[ADDR_W-1 -: TAG_W]),
    .fill_dirty (fill_dirty),
    .clr_all    (inv_all),
    .clr_en     (clr_en),
    .clr_idx    (clr_idx),
    .clr_valid  (clr_valid),
    .rd_a_idx   (walk_idx),
    .rd_a_valid (cur_valid),
    .rd_a_dirty (cur_dirty),
    .rd_a_tag   (cur_tag),
    .rd_b_idx   (lkp_addr[OFF_W +: IDX_W]),
    .rd_b_valid (lkp_valid),
    .rd_b_dirty (lkp_dirty),
    .valid_vec  (line_valid_vec)
  );

  assign wb_addr  = {cur_tag, walk_idx, {OFF_W{1'b0}}};
  assign cache_on = ~ctrl_dis;

  always_comb begin
    ctrl_rd            = '0;
    ctrl_rd[DIS_BIT]   = ctrl_dis;
    ctrl_rd[IMODE_BIT] = ctrl_imode;
    ctrl_rd[BUSY_BIT]  = busy;
  end
endmodule

// File: rtl/dcache_maint_chk.sv
`timescale 1ns/1ps
module dcache_maint_chk #(
  parameter int ADDR_W    = 32,
  parameter int NUM_LINES = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic                 cmd_ready,
  input logic [2:0]           cmd_sel,
  input logic                 wd_dis,
  input logic                 wd_mode,
  input logic [31:0]          ctrl_rd,
  input logic                 wb_valid,
  input logic                 wb_ready,
  input logic [ADDR_W-1:0]    wb_addr,
  input logic [NUM_LINES-1:0] valid_vec
);
  logic acc, plain_inv, with_wb;
  assign acc       = cmd_valid && cmd_ready;
  assign plain_inv = acc && (cmd_sel == 3'd1 || cmd_sel == 3'd3) && !ctrl_rd[6];
  assign with_wb   = acc && (cmd_sel == 3'd2 || cmd_sel == 3'd4 ||
                     ((cmd_sel == 3'd1 || cmd_sel == 3'd3) && ctrl_rd[6]));

  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_sel == 3'd0) |=> (ctrl_rd[0] == $past(wd_dis) && ctrl_rd[6] == $past(wd_mode)));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd & ~32'h0000_0141) == 32'h0);

  assert_plain_inv_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    plain_inv |=> !ctrl_rd[8]);

  assert_flush_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    with_wb |=> ctrl_rd[8]);

  assert_wb_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ctrl_rd[8]);

  assert_inv_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_inv && cmd_sel == 3'd1) |=> (valid_vec == '0));

  assert_wb_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr)));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[8] |-> !cmd_ready);
endmodule

bind dcache_maint dcache_maint_chk #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_sel   (cmd_sel),
  .wd_dis    (cmd_wdata[0]),
  .wd_mode   (cmd_wdata[6]),
  .ctrl_rd   (ctrl_rd),
  .wb_valid  (wb_valid),
  .wb_ready  (wb_ready),
  .wb_addr   (wb_addr),
  .valid_vec (line_valid_vec)
);

// File: tb/dcache_maint_tb.sv
`timescale 1ns/1ps
module dcache_maint_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_sel = '0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] ctrl_rd;
  logic        cache_on;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_addr = '0;
  logic        fill_dirty = 1'b0;
  logic [31:0] lkp_addr = '0;
  logic        lkp_valid, lkp_dirty;
  logic        wb_valid;
  logic        wb_ready = 1'b0;
  logic [31:0] wb_addr;

  int n_chk = 0;
  int n_err = 0;
  int wb_n = 0;
  logic [31:0] wb_log [64];
  logic mem_hold = 1'b0;
  logic [1:0] pat = '0;
  logic stall_done = 1'b0;

  always #2.5 clk = ~clk;

  dcache_maint u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_sel(cmd_sel), .cmd_wdata(cmd_wdata), .ctrl_rd(ctrl_rd), .cache_on(cache_on),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_dirty(fill_dirty),
    .lkp_addr(lkp_addr), .lkp_valid(lkp_valid), .lkp_dirty(lkp_dirty),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr)
  );

  // Memory side: ready three cycles in four unless held.
  always @(negedge clk) begin
    pat = pat + 2'd1;
    wb_ready = !mem_hold && (pat != 2'd0);
  end

  always @(posedge clk) begin
    if (rst_n && wb_valid && wb_ready) begin
      if (wb_n < 64) wb_log[wb_n] = wb_addr;
      wb_n = wb_n + 1;
    end
  end

  function automatic logic [31:0] la(input int tag, input int idx);
    return (32'(tag) << 9) | (32'(idx) << 5);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_sel   = sel;
    cmd_wdata = data;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (ctrl_rd[8] && t < 2000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic fill(input logic [31:0] a, input logic d);
    @(negedge clk);
    fill_valid = 1'b1;
    fill_addr  = a;
    fill_dirty = d;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic look(input logic [31:0] a, output logic [1:0] vd);
    lkp_addr = a;
    #0.1;
    vd = {lkp_valid, lkp_dirty};
  endtask

  task automatic count_valid(output int n);
    logic [1:0] vd;
    n = 0;
    for (int i = 0; i < 16; i++) begin
      look(la(0, i), vd);
      if (vd[1]) n++;
    end
  endtask

  task automatic t_reset();
    int n;
    check("R1 ctrl word", ctrl_rd, 32'h0);
    check("R1 cmd_ready", 32'(cmd_ready), 32'h1);
    check("R1 wb_valid", 32'(wb_valid), 32'h0);
    count_valid(n);
    check("R1 valid lines", 32'(n), 32'h0);
  endtask

  task automatic t_ctrl();
    logic [1:0] vd;
    send(3'd0, 32'hFFFF_FFFF);
    check("R2 ctrl readback", ctrl_rd, 32'h41);
    check("R2 cache_on off", 32'(cache_on), 32'h0);
    fill(la(7, 2), 1'b1);
    look(la(7, 2), vd);
    check("R2 fill ignored while off", 32'(vd), 32'h0);
    send(3'd0, 32'h0);
    check("R2 ctrl cleared", ctrl_rd, 32'h0);
    check("R2 cache_on on", 32'(cache_on), 32'h1);
  endtask

  task automatic t_fill();
    logic [1:0] vd;
    fill(la(11, 1), 1'b1);
    fill(la(13, 3), 1'b0);
    fill(la(15, 5), 1'b1);
    fill(la(17, 15), 1'b1);
    look(la(11, 1), vd);  check("R12 line1 dirty fill", 32'(vd), 32'h3);
    look(la(13, 3), vd);  check("R12 line3 clean fill", 32'(vd), 32'h2);
    look(la(0, 4), vd);   check("R11 line4 empty", 32'(vd), 32'h0);
    look(la(99, 15) | 32'h1F, vd); check("R11 lookup by index only", 32'(vd), 32'h3);
  endtask

  task automatic t_flush_all();
    logic [1:0] vd;
    wb_n = 0;
    send(3'd2, 32'h0);
    check("R3 busy after flush", 32'(ctrl_rd[8]), 32'h1);
    wait_idle();
    check("R5 writeback count", 32'(wb_n), 32'd3);
    check("R5 first wb", wb_log[0], la(11, 1));
    check("R5 second wb", wb_log[1], la(15, 5));
    check("R9 third wb addr", wb_log[2], la(17, 15));
    look(la(0, 1), vd);  check("R5 line1 valid clean", 32'(vd), 32'h2);
    look(la(0, 15), vd); check("R5 line15 valid clean", 32'(vd), 32'h2);
  endtask

  task automatic t_flush_clean();
    logic [1:0] vd;
    wb_n = 0;
    send(3'd4, la(13, 3));
    wait_idle();
    check("R8 clean flush no request", 32'(wb_n), 32'h0);
    look(la(0, 3), vd); check("R8 clean line kept", 32'(vd), 32'h2);
  endtask

  task automatic t_flush_line();
    logic [1:0] vd;
    fill(la(21, 6), 1'b1);
    fill(la(23, 7), 1'b1);
    wb_n = 0;
    send(3'd4, la(21, 6) | 32'h1C);
    wait_idle();
    check("R7 line flush count", 32'(wb_n), 32'h1);
    check("R7 offset ignored addr", wb_log[0], la(21, 6));
    look(la(0, 7), vd); check("R7 neighbour untouched", 32'(vd), 32'h3);
    look(la(0, 6), vd); check("R7 flushed line clean", 32'(vd), 32'h2);
  endtask

  task automatic t_inv_line_plain();
    logic [1:0] vd;
    wb_n = 0;
    send(3'd3, la(23, 7) | 32'h3);
    check("R3 plain inv no busy", 32'(ctrl_rd[8]), 32'h0);
    look(la(0, 7), vd); check("R7 line7 discarded", 32'(vd), 32'h0);
    look(la(0, 6), vd); check("R7 line6 untouched", 32'(vd), 32'h2);
    repeat (4) @(negedge clk);
    check("R7 plain inv no request", 32'(wb_n), 32'h0);
  endtask

  task automatic t_inv_line_wb();
    logic [1:0] vd;
    send(3'd0, 32'h40);
    fill(la(25, 9), 1'b1);
    wb_n = 0;
    send(3'd3, la(25, 9));
    check("R3 busy on wb-invalidate", 32'(ctrl_rd[8]), 32'h1);
    wait_idle();
    check("R6 line wb count", 32'(wb_n), 32'h1);
    check("R6 line wb addr", wb_log[0], la(25, 9));
    look(la(0, 9), vd); check("R6 line9 invalid", 32'(vd), 32'h0);
    wb_n = 0;
    send(3'd3, la(0, 10));
    wait_idle();
    check("R8 absent line no request", 32'(wb_n), 32'h0);
  endtask

  task automatic t_inv_all_wb();
    int n;
    fill(la(31, 2), 1'b1);
    fill(la(33, 12), 1'b1);
    fill(la(35, 0), 1'b0);
    wb_n = 0;
    send(3'd1, 32'h0);
    wait_idle();
    check("R6 whole wb count", 32'(wb_n), 32'd2);
    check("R6 whole wb first", wb_log[0], la(31, 2));
    check("R6 whole wb second", wb_log[1], la(33, 12));
    count_valid(n);
    check("R6 all invalid", 32'(n), 32'h0);
  endtask

  task automatic t_inv_all_plain();
    int n;
    send(3'd0, 32'h0);
    fill(la(41, 4), 1'b1);
    fill(la(43, 8), 1'b0);
    wb_n = 0;
    send(3'd1, 32'h0);
    check("R3 whole plain inv no busy", 32'(ctrl_rd[8]), 32'h0);
    count_valid(n);
    check("R4 all invalid", 32'(n), 32'h0);
    repeat (20) @(negedge clk);
    check("R4 no request", 32'(wb_n), 32'h0);
  endtask

  task automatic t_stall();
    logic [1:0] vd;
    fill(la(51, 11), 1'b1);
    fill(la(53, 13), 1'b1);
    wb_n = 0;
    mem_hold = 1'b1;
    send(3'd2, 32'h0);
    repeat (20) @(negedge clk);
    check("R9 wb raised", 32'(wb_valid), 32'h1);
    check("R9 wb addr", wb_addr, la(51, 11));
    repeat (5) @(negedge clk);
    check("R9 wb held valid", 32'(wb_valid), 32'h1);
    check("R9 wb addr stable", wb_addr, la(51, 11));
    fork
      begin
        send(3'd3, la(53, 13));
        stall_done = 1'b1;
      end
    join_none
    @(negedge clk);
    @(negedge clk);
    check("R10 ready low while busy", 32'(cmd_ready), 32'h0);
    look(la(0, 13), vd); check("R10 command held", 32'(vd), 32'h3);
    mem_hold = 1'b0;
    wait (stall_done);
    @(negedge clk);
    check("R10 flush writes", 32'(wb_n), 32'd2);
    check("R10 second wb", wb_log[1], la(53, 13));
    look(la(0, 13), vd); check("R10 held inv applied", 32'(vd), 32'h0);
    look(la(0, 11), vd); check("R5 line11 clean", 32'(vd), 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_fill();
    t_flush_all();
    t_flush_clean();
    t_flush_line();
    t_inv_line_plain();
    t_inv_line_wb();
    t_inv_all_wb();
    t_inv_all_plain();
    t_stall();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule